// File: doc/BRIEF.md
# Main Control Decoder

This block turns the 6-bit primary operation field of a 32-bit load/store instruction word into the datapath steering lines of a single-cycle processor. These lines are the write-register source, the second ALU operand source, the write-back source, the register-file write enable, the data-memory read and write strobes, the equal-branch qualifier and a 2-bit ALU mode. It decodes five instruction classes: register-register arithmetic, word load, word store, branch-on-equal and add-immediate. Add-immediate uses the datapath exactly as it is. It only adds one row to the decode table, which selects the immediate operand, an add, and write-back of the ALU result into the register named by the rt field.

The outputs are registered, with a synchronous active-high reset that clears every line. The registered outputs fit an FPGA flow where the decode is done in a pipeline slot ahead of use. Every operation code value is a parameter. Any code outside the five classes drives all outputs to 0, so it cannot write a register, access memory or branch.

Top module: `main_ctrl_decoder`

## Requirements
- R1: While `rst` is sampled high at a rising edge, every output is 0 after that edge, whatever `op_i` is.
- R2: Outputs are registered: the values seen after rising edge N depend only on the `op_i` sampled at edge N.
- R3: Code 6'b000000 (register-register) gives dst_rd=1, opb_imm=0, wb_mem=0, rf_we=1, dmem_re=0, dmem_we=0, br_eq=0, alu_mode=2'b10.
- R4: Code 6'b100011 (word load) gives dst_rd=0, opb_imm=1, wb_mem=1, rf_we=1, dmem_re=1, dmem_we=0, br_eq=0, alu_mode=2'b00.
- R5: Code 6'b101011 (word store) gives opb_imm=1, dmem_we=1 and every other output 0, alu_mode=2'b00.
- R6: Code 6'b000100 (branch-on-equal) gives br_eq=1, alu_mode=2'b01 and every other output 0.
- R7: Code 6'b001000 (add-immediate) gives dst_rd=0, opb_imm=1, wb_mem=0, rf_we=1, dmem_re=0, dmem_we=0, br_eq=0, alu_mode=2'b00 (add).
- R8: Any other code gives every output 0, including rf_we, dmem_we, dmem_re and br_eq.
- R9: At most one of dmem_re, dmem_we and br_eq is ever high, and dmem_we is never high together with rf_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 6 | Primary operation field of the instruction |
| dst_rd_o | output | 1 | 1: write register from rd field, 0: from rt field |
| opb_imm_o | output | 1 | 1: second ALU operand is the sign-extended immediate |
| wb_mem_o | output | 1 | 1: write-back data from memory, 0: from ALU |
| rf_we_o | output | 1 | Register-file write enable |
| dmem_re_o | output | 1 | Data-memory read strobe |
| dmem_we_o | output | 1 | Data-memory write strobe |
| br_eq_o | output | 1 | Branch-on-equal qualifier |
| alu_mode_o | output | 2 | 00 add, 01 subtract, 10 use function field |

## Verification
The bench instantiates the decoder with its default parameters: a 6-bit code field and the five standard code values. With this width the whole code space has only 64 entries, so the bench sweeps every code in order. This makes every unknown code observable, not just a sample of them. Random back-to-back codes follow the sweep to test the single-cycle registered latency, and reset pulses applied while a writing code is present test the clear.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

  localparam int ALU_MODE_W = 2;
  localparam int NUM_CLASS  = 5;

  typedef enum logic [2:0] {
    CL_NONE   = 3'd0,
    CL_RTYPE  = 3'd1,
    CL_LOAD   = 3'd2,
    CL_STORE  = 3'd3,
    CL_BRANCH = 3'd4,
    CL_ADDI   = 3'd5
  } class_e;

  typedef struct packed {
    logic                  dst_rd;
    logic                  opb_imm;
    logic                  wb_mem;
    logic                  rf_we;
    logic                  dmem_re;
    logic                  dmem_we;
    logic                  br_eq;
    logic [ALU_MODE_W-1:0] alu_mode;
  } ctrl_t;

  localparam ctrl_t CTRL_SAFE = '0;

endpackage

// File: rtl/op_classify.sv
module op_classify
  import ctrl_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OP_W-1:0] OP_ADDI   = 6'b001000
) (
  input  logic [OP_W-1:0] op_i,
  output class_e          cls_o
);

  // code list in class-enum order (entry k maps to enum value k+1)
  localparam logic [OP_W-1:0] CODES [NUM_CLASS] =
    '{OP_RTYPE, OP_LOAD, OP_STORE, OP_BRANCH, OP_ADDI};

  logic [NUM_CLASS-1:0] hit;

  for (genvar k = 0; k < NUM_CLASS; k++) begin : g_match
    assign hit[k] = (op_i == CODES[k]);
  end

  always_comb begin
    cls_o = CL_NONE;
    for (int k = NUM_CLASS - 1; k >= 0; k--) begin
      if (hit[k]) cls_o = class_e'(k + 1);
    end
  end

  // distinct parameter codes keep at most one match active
  always_comb begin
    assert ($onehot0(hit) || $isunknown(op_i))
      else $error("p_single_match_r8: overlapping code parameters");
  end

endmodule

// File: rtl/ctrl_table.sv
module ctrl_table
  import ctrl_pkg::*;
(
  input  class_e cls_i,
  output ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = CTRL_SAFE;
    unique case (cls_i)
      CL_RTYPE: begin
        ctrl_o.dst_rd   = 1'b1;
        ctrl_o.rf_we    = 1'b1;
        ctrl_o.alu_mode = 2'b10;
      end
      CL_LOAD: begin
        ctrl_o.opb_imm  = 1'b1;
        ctrl_o.wb_mem   = 1'b1;
        ctrl_o.rf_we    = 1'b1;
        ctrl_o.dmem_re  = 1'b1;
      end
      CL_STORE: begin
        ctrl_o.opb_imm  = 1'b1;
        ctrl_o.dmem_we  = 1'b1;
      end
      CL_BRANCH: begin
        ctrl_o.br_eq    = 1'b1;
        ctrl_o.alu_mode = 2'b01;
      end
      CL_ADDI: begin
        ctrl_o.opb_imm  = 1'b1;
        ctrl_o.rf_we    = 1'b1;
      end
      default: ctrl_o = CTRL_SAFE;
    endcase
  end

endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
  import ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t d_i,
  output ctrl_t q_o
);

  always_ff @(posedge clk) begin
    if (rst) q_o <= CTRL_SAFE;
    else     q_o <= d_i;
  end

endmodule

// File: rtl/main_ctrl_decoder.sv
module main_ctrl_decoder
  import ctrl_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OP_W-1:0] OP_ADDI   = 6'b001000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [OP_W-1:0]       op_i,
  output logic                  dst_rd_o,
  output logic                  opb_imm_o,
  output logic                  wb_mem_o,
  output logic                  rf_we_o,
  output logic                  dmem_re_o,
  output logic                  dmem_we_o,
  output logic                  br_eq_o,
  output logic [ALU_MODE_W-1:0] alu_mode_o
);

  class_e cls;
  ctrl_t  ctrl_d;
  ctrl_t  ctrl_q;

  op_classify #(
    .OP_W     (OP_W),
    .OP_RTYPE (OP_RTYPE),
    .OP_LOAD  (OP_LOAD),
    .OP_STORE (OP_STORE),
    .OP_BRANCH(OP_BRANCH),
    .OP_ADDI  (OP_ADDI)
  ) i_classify (
    .op_i (op_i),
    .cls_o(cls)
  );

  ctrl_table i_table (
    .cls_i (cls),
    .ctrl_o(ctrl_d)
  );

  ctrl_reg i_reg (
    .clk(clk),
    .rst(rst),
    .d_i(ctrl_d),
    .q_o(ctrl_q)
  );

  assign dst_rd_o   = ctrl_q.dst_rd;
  assign opb_imm_o  = ctrl_q.opb_imm;
  assign wb_mem_o   = ctrl_q.wb_mem;
  assign rf_we_o    = ctrl_q.rf_we;
  assign dmem_re_o  = ctrl_q.dmem_re;
  assign dmem_we_o  = ctrl_q.dmem_we;
  assign br_eq_o    = ctrl_q.br_eq;
  assign alu_mode_o = ctrl_q.alu_mode;

  // port-level timing checks: code sampled at one edge, outputs after it
  p_rtype_rows_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RTYPE) |=> (rf_we_o && dst_rd_o && !opb_imm_o && alu_mode_o == 2'b10))
    else $error("p_rtype_rows_r3");

  p_load_rows_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LOAD) |=> (rf_we_o && dmem_re_o && wb_mem_o && opb_imm_o && !dmem_we_o))
    else $error("p_load_rows_r4");

  p_store_rows_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_STORE) |=> (dmem_we_o && opb_imm_o && !rf_we_o && !dmem_re_o))
    else $error("p_store_rows_r5");

  p_branch_rows_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_BRANCH) |=> (br_eq_o && alu_mode_o == 2'b01 && !rf_we_o && !dmem_we_o))
    else $error("p_branch_rows_r6");

  p_addi_rows_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADDI) |=> (rf_we_o && opb_imm_o && !dst_rd_o && !wb_mem_o && alu_mode_o == 2'b00))
    else $error("p_addi_rows_r7");

  p_unknown_safe_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i != OP_RTYPE && op_i != OP_LOAD && op_i != OP_STORE &&
     op_i != OP_BRANCH && op_i != OP_ADDI) |=>
    (!rf_we_o && !dmem_we_o && !dmem_re_o && !br_eq_o))
    else $error("p_unknown_safe_r8");

  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    ($countones({dmem_re_o, dmem_we_o, br_eq_o}) <= 1) && !(dmem_we_o && rf_we_o))
    else $error("p_exclusive_r9");

endmodule

// File: tb/test_main_ctrl_decoder.sv
module test_main_ctrl_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int OP_W       = 6;

  logic            clk = 1'b0;
  logic            rst;
  logic [OP_W-1:0] op;
  logic            dst_rd, opb_imm, wb_mem, rf_we, dmem_re, dmem_we, br_eq;
  logic [1:0]      alu_mode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  main_ctrl_decoder i_main_ctrl_decoder (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op),
    .dst_rd_o  (dst_rd),
    .opb_imm_o (opb_imm),
    .wb_mem_o  (wb_mem),
    .rf_we_o   (rf_we),
    .dmem_re_o (dmem_re),
    .dmem_we_o (dmem_we),
    .br_eq_o   (br_eq),
    .alu_mode_o(alu_mode)
  );

  // expected {dst_rd, opb_imm, wb_mem, rf_we, dmem_re, dmem_we, br_eq, alu_mode}
  function automatic logic [8:0] expect_ctrl(input logic [OP_W-1:0] c);
    case (c)
      6'b000000: return 9'b1_0_0_1_0_0_0_10; // R3
      6'b100011: return 9'b0_1_1_1_1_0_0_00; // R4
      6'b101011: return 9'b0_1_0_0_0_1_0_00; // R5
      6'b000100: return 9'b0_0_0_0_0_0_1_01; // R6
      6'b001000: return 9'b0_1_0_1_0_0_0_00; // R7
      default:   return 9'b0;                // R8
    endcase
  endfunction

  function automatic string req_of(input logic [OP_W-1:0] c);
    case (c)
      6'b000000: return "R3";
      6'b100011: return "R4";
      6'b101011: return "R5";
      6'b000100: return "R6";
      6'b001000: return "R7";
      default:   return "R8";
    endcase
  endfunction

  function automatic logic [8:0] outs();
    return {dst_rd, opb_imm, wb_mem, rf_we, dmem_re, dmem_we, br_eq, alu_mode};
  endfunction

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic check_r9();
    checks++;
    if (($countones({dmem_re, dmem_we, br_eq}) > 1) || (dmem_we && rf_we)) begin
      errors++;
      $display("FAIL R9 got re/we/br/rfwe %b%b%b%b expected exclusive",
               dmem_re, dmem_we, br_eq, rf_we);
    end
  endtask

  // drive a code, then check after the next edge (R2 latency of one edge)
  task automatic apply_check(input logic [OP_W-1:0] c);
    op = c;
    @(negedge clk);
    check({"R2/", req_of(c)}, outs(), expect_ctrl(c));
    check_r9();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [OP_W-1:0] prev;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    op  = 6'b000000;
    @(negedge clk);
    @(negedge clk);
    // R1: reset clears even with a writing code present
    check("R1", outs(), 9'b0);
    op = 6'b100011;
    @(negedge clk);
    check("R1", outs(), 9'b0);
    rst = 1'b0;

    // directed corner codes
    apply_check(6'b000000);
    apply_check(6'b100011);
    apply_check(6'b101011);
    apply_check(6'b000100);
    apply_check(6'b001000);
    apply_check(6'b111111);
    apply_check(6'b001001);
    apply_check(6'b000001);

    // exhaustive sweep of the code space
    for (int k = 0; k < (1 << OP_W); k++) apply_check(OP_W'(k));

    // back-to-back random codes, biased toward known classes
    for (int n = 0; n < 300; n++) begin
      logic [OP_W-1:0] c;
      case ($urandom_range(0, 5))
        0: c = 6'b000000;
        1: c = 6'b100011;
        2: c = 6'b101011;
        3: c = 6'b000100;
        4: c = 6'b001000;
        default: c = OP_W'($urandom);
      endcase
      apply_check(c);
    end

    // R2: outputs hold the previous code until the next edge
    op = 6'b001000;
    @(negedge clk);
    prev = op;
    op = 6'b101011;
    #1;
    check("R2", outs(), expect_ctrl(prev));
    @(negedge clk);
    check("R2", outs(), expect_ctrl(6'b101011));

    // R1: mid-run reset with add-immediate present
    op  = 6'b001000;
    rst = 1'b1;
    @(negedge clk);
    check("R1", outs(), 9'b0);
    rst = 1'b0;
    apply_check(6'b001000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule